// File: doc/BRIEF.md
# Product-Term AND Plane with Mode-Dependent Column Routing

This block is the programmable AND plane of a sixteen-input, eight-output logic array. Sixteen signal sources feed it: eight dedicated inputs and eight feedback slots, one slot per output cell. Each source drives two adjacent array columns, one with its true form and one with its complement. A flat fuse vector selects which of the 32 columns each of the 64 product terms takes in. A per-term enable can force any term to zero. The terms leave the block in groups of eight, one group per output cell, and are registered once on the way out.

What each feedback slot carries depends on the global mode.

- **Registered mode:** each slot carries its own cell's register state or pin level. The two shared pins play no part as data.
- **Complex mode:** the two shared pins take over the slots of the outermost cells, so those two cells lose their feedback.
- **Simple mode:** every slot is fed from the neighbouring cell on its outward side, and the outermost slots carry the shared pins. As a result, the two centre cells feed no column.

The register state, pin levels and per-cell kind come from the surrounding output-cell logic. Configuration storage lives outside this block.

Top module: `pla_and_plane`

## Requirements
- R1: While rst_ni is low, pt_o is all zeros.
- R2: pt_o changes only at a rising clock edge and reflects the inputs sampled at that edge. A new input value is not visible before the next edge.
- R3: Source k drives column 2k with its true value and column 2k+1 with its complement. Sources 0..7 are ded_i[0..7]. Sources 8..15 are feedback slots 0..7.
- R4: Term r uses fuse_i bits [32r+31:32r], and bit c of that field connects column c. The term is the AND of every connected column. Terms 8c..8c+7 belong to output cell c.
- R5: An enabled term with all 32 fuse bits set is 0. An enabled term with no fuse bit set is 1.
- R6: When term_en_i[r] is 0, pt_o[r] is 0 whatever its fuses and sources are.
- R7: Registered mode is mode_i = 2 or 3. Slot j carries io_pin_i[j] when cell_comb_i[j] is 1, and reg_q_i[j] when it is 0. shared_a_i and shared_b_i have no effect.
- R8: Complex mode is mode_i = 1.
  - Slot 7 carries shared_a_i and slot 0 carries shared_b_i.
  - Slots 1..6 carry io_pin_i[1..6].
  - io_pin_i[0], io_pin_i[7], reg_q_i and cell_comb_i have no effect.
- R9: Simple mode is mode_i = 0.
  - Slot 0 carries shared_b_i and slot 7 carries shared_a_i.
  - Slots 1..3 carry io_pin_i[0..2] and slots 4..6 carry io_pin_i[5..7].
  - io_pin_i[3], io_pin_i[4], reg_q_i and cell_comb_i have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the term register |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Global mode: 0 simple, 1 complex, 2 or 3 registered |
| ded_i | input | 8 | Dedicated data inputs |
| shared_a_i | input | 1 | Data level of the shared clock pin |
| shared_b_i | input | 1 | Data level of the shared enable pin |
| io_pin_i | input | 8 | Pin level of each output cell |
| reg_q_i | input | 8 | Register state of each output cell |
| cell_comb_i | input | 8 | Per-cell kind in registered mode: 1 combinational, 0 registered |
| fuse_i | input | 2048 | Connection fuses, 32 bits per term |
| term_en_i | input | 64 | Per-term enable |
| pt_o | output | 64 | Registered product terms, eight per output cell |

## Verification
Two behaviours can act on the same term in the same cycle: the per-term disable and a row whose fuses force a fixed value, either all set or all clear. The bench provokes this by driving every row clear while a sparse enable pattern is applied, and it expects exactly the enable pattern at the output. Mode switching and a change to a routed source also land in one cycle. The bench judges this with single-column probe rows: each of the first 32 terms exposes one column. After a mode change it toggles the sources that the new mode must ignore and requires the exposed columns to stay the same.

// File: rtl/pla_pkg.sv
package pla_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  typedef enum logic [1:0] {
    MODE_SIMPLE  = 2'd0,
    MODE_COMPLEX = 2'd1,
    MODE_REG     = 2'd2,
    MODE_REG_ALT = 2'd3
  } mode_e;
endpackage

// File: rtl/pla_col_route.sv
module pla_col_route #(
  parameter int unsigned N_DED  = 8,
  parameter int unsigned N_CELL = 8,
  localparam int unsigned N_SRC = N_DED + N_CELL,
  localparam int unsigned N_COL = 2 * N_SRC
) (
  input  pla_pkg::mode_e    mode_i,
  input  logic [N_DED-1:0]  ded_i,
  input  logic              shared_a_i,
  input  logic              shared_b_i,
  input  logic [N_CELL-1:0] io_pin_i,
  input  logic [N_CELL-1:0] reg_q_i,
  input  logic [N_CELL-1:0] cell_comb_i,
  output logic [N_COL-1:0]  col_o
);
  timeunit 1ns;
  timeprecision 1ps;
  import pla_pkg::*;

  localparam int unsigned HALF = N_CELL / 2;

  logic [N_CELL-1:0] slot;
  logic [N_SRC-1:0]  src;

  for (genvar j = 0; j < N_CELL; j++) begin : g_slot
    logic own_fb;
    assign own_fb = cell_comb_i[j] ? io_pin_i[j] : reg_q_i[j];

    if (j == 0) begin : g_outer_lo
      always_comb begin
        unique case (mode_i)
          MODE_SIMPLE, MODE_COMPLEX: slot[j] = shared_b_i;
          default:                   slot[j] = own_fb;
        endcase
      end
    end else if (j == N_CELL - 1) begin : g_outer_hi
      always_comb begin
        unique case (mode_i)
          MODE_SIMPLE, MODE_COMPLEX: slot[j] = shared_a_i;
          default:                   slot[j] = own_fb;
        endcase
      end
    end else if (j < HALF) begin : g_lower
      // simple mode borrows the outward neighbour
      always_comb begin
        unique case (mode_i)
          MODE_SIMPLE:  slot[j] = io_pin_i[j-1];
          MODE_COMPLEX: slot[j] = io_pin_i[j];
          default:      slot[j] = own_fb;
        endcase
      end
    end else begin : g_upper
      always_comb begin
        unique case (mode_i)
          MODE_SIMPLE:  slot[j] = io_pin_i[j+1];
          MODE_COMPLEX: slot[j] = io_pin_i[j];
          default:      slot[j] = own_fb;
        endcase
      end
    end
  end

  assign src = {slot, ded_i};

  for (genvar k = 0; k < N_SRC; k++) begin : g_col
    assign col_o[2*k]   = src[k];
    assign col_o[2*k+1] = ~src[k];
  end
endmodule

// File: rtl/pla_term_row.sv
module pla_term_row #(
  parameter int unsigned N_COL = 32
) (
  input  logic [N_COL-1:0] fuse_i,
  input  logic [N_COL-1:0] col_i,
  input  logic             en_i,
  output logic             term_o
);
  timeunit 1ns;
  timeprecision 1ps;

  // unconnected columns read as 1 in the AND
  assign term_o = en_i & (&(col_i | ~fuse_i));
endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
  parameter int unsigned N_DED          = 8,
  parameter int unsigned N_CELL         = 8,
  parameter int unsigned TERMS_PER_CELL = 8,
  localparam int unsigned N_SRC     = N_DED + N_CELL,
  localparam int unsigned N_COL     = 2 * N_SRC,
  localparam int unsigned N_TERM    = N_CELL * TERMS_PER_CELL,
  localparam int unsigned FUSE_BITS = N_TERM * N_COL
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [1:0]           mode_i,
  input  logic [N_DED-1:0]     ded_i,
  input  logic                 shared_a_i,
  input  logic                 shared_b_i,
  input  logic [N_CELL-1:0]    io_pin_i,
  input  logic [N_CELL-1:0]    reg_q_i,
  input  logic [N_CELL-1:0]    cell_comb_i,
  input  logic [FUSE_BITS-1:0] fuse_i,
  input  logic [N_TERM-1:0]    term_en_i,
  output logic [N_TERM-1:0]    pt_o
);
  timeunit 1ns;
  timeprecision 1ps;
  import pla_pkg::*;

  logic [N_COL-1:0]  col;
  logic [N_TERM-1:0] term_d;
  logic [N_TERM-1:0] pt_q;

  pla_col_route #(
    .N_DED (N_DED),
    .N_CELL(N_CELL)
  ) u_route (
    .mode_i     (mode_e'(mode_i)),
    .ded_i      (ded_i),
    .shared_a_i (shared_a_i),
    .shared_b_i (shared_b_i),
    .io_pin_i   (io_pin_i),
    .reg_q_i    (reg_q_i),
    .cell_comb_i(cell_comb_i),
    .col_o      (col)
  );

  for (genvar r = 0; r < N_TERM; r++) begin : g_row
    pla_term_row #(.N_COL(N_COL)) u_row (
      .fuse_i(fuse_i[r*N_COL +: N_COL]),
      .col_i (col),
      .en_i  (term_en_i[r]),
      .term_o(term_d[r])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pt_q <= '0;
    else         pt_q <= term_d;
  end

  assign pt_o = pt_q;

  // ---------------- assertions ----------------
  localparam int unsigned IN_W = 2 + N_DED + 2 + 3 * N_CELL + FUSE_BITS + N_TERM;

  logic [IN_W-1:0] in_bus;
  logic [1:0]      warm_q;

  assign in_bus = {mode_i, ded_i, shared_a_i, shared_b_i, io_pin_i, reg_q_i,
                   cell_comb_i, fuse_i, term_en_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              warm_q <= '0;
    else if (warm_q != 2'd3)  warm_q <= warm_q + 2'd1;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk_i) !rst_ni |=> (pt_o == '0) || rst_ni);

  // R2
  hold_when_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd3 && $past(in_bus) == $past(in_bus, 2)) |-> $stable(pt_o));

  for (genvar r = 0; r < N_TERM; r++) begin : g_row_chk
    // R6
    term_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (warm_q != 2'd0 && !$past(term_en_i[r])) |-> !pt_o[r]);
    // R5
    full_row_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (warm_q != 2'd0 && (&$past(fuse_i[r*N_COL +: N_COL]))) |-> !pt_o[r]);
    // R5
    empty_row_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (warm_q != 2'd0 && $past(fuse_i[r*N_COL +: N_COL]) == '0 && $past(term_en_i[r]))
        |-> pt_o[r]);
  end
endmodule

// File: tb/sim_pla_and_plane.sv
module sim_pla_and_plane;
  timeunit 1ns;
  timeprecision 1ps;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [1:0]    mode_i = '0;
  logic [7:0]    ded_i = '0;
  logic          shared_a_i = 1'b0;
  logic          shared_b_i = 1'b0;
  logic [7:0]    io_pin_i = '0;
  logic [7:0]    reg_q_i = '0;
  logic [7:0]    cell_comb_i = '0;
  logic [2047:0] fuse_i = '0;
  logic [63:0]   term_en_i = '1;
  logic [63:0]   pt_o;

  int total = 0;
  int bad = 0;

  always #2.5 clk_i = ~clk_i;

  pla_and_plane u0 (
    .clk_i, .rst_ni, .mode_i, .ded_i, .shared_a_i, .shared_b_i,
    .io_pin_i, .reg_q_i, .cell_comb_i, .fuse_i, .term_en_i, .pt_o
  );

  function automatic logic [15:0] src_of(logic [1:0] m, logic [7:0] d, logic sa, logic sb,
                                         logic [7:0] io, logic [7:0] q, logic [7:0] cb);
    logic [7:0] s;
    case (m)
      2'd0: s = {sa, io[7], io[6], io[5], io[2], io[1], io[0], sb};
      2'd1: s = {sa, io[6:1], sb};
      default: for (int j = 0; j < 8; j++) s[j] = cb[j] ? io[j] : q[j];
    endcase
    return {s, d};
  endfunction

  function automatic logic [31:0] cols_of(logic [15:0] s);
    logic [31:0] c;
    for (int k = 0; k < 16; k++) begin
      c[2*k]   = s[k];
      c[2*k+1] = ~s[k];
    end
    return c;
  endfunction

  function automatic logic [63:0] model();
    logic [31:0] c;
    logic [63:0] p;
    c = cols_of(src_of(mode_i, ded_i, shared_a_i, shared_b_i, io_pin_i, reg_q_i, cell_comb_i));
    for (int r = 0; r < 64; r++) p[r] = term_en_i[r] & (&(c | ~fuse_i[r*32 +: 32]));
    return p;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive at negedge, sample one time unit after the next rising edge
  task automatic step();
    @(posedge clk_i);
    #1;
  endtask

  task automatic rand_fuses();
    for (int w = 0; w < 64; w++) fuse_i[w*32 +: 32] = $urandom & $urandom & $urandom;
  endtask

  task automatic rand_srcs();
    ded_i = 8'($urandom); shared_a_i = 1'($urandom); shared_b_i = 1'($urandom);
    io_pin_i = 8'($urandom); reg_q_i = 8'($urandom); cell_comb_i = 8'($urandom);
  endtask

  task automatic probe_fuses();
    fuse_i = '0;
    for (int r = 0; r < 32; r++) fuse_i[r*32 + r] = 1'b1;
    term_en_i = {32'h0, 32'hFFFF_FFFF};
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [63:0] prev;
    logic [31:0] exp_c;
    void'($urandom(32'd1234));

    // R1: terms would all be 1, but reset holds them low
    fuse_i = '0; term_en_i = '1;
    step();
    check("R1 reset", pt_o, 64'h0);
    step();
    check("R1 reset hold", pt_o, 64'h0);
    @(negedge clk_i); rst_ni = 1'b1;
    step();

    // R5 empty rows
    check("R5 empty rows", pt_o, '1);

    // R5 full rows, R2 latency
    @(negedge clk_i); fuse_i = '1;
    #1 check("R2 no change before edge", pt_o, '1);
    step();
    check("R5 full rows", pt_o, 64'h0);

    // R6 with R5 in the same cycle
    @(negedge clk_i); fuse_i = '0; term_en_i = 64'hA5C3_0F11_8000_0001;
    step();
    check("R6 disable pattern", pt_o, 64'hA5C3_0F11_8000_0001);

    // R3 via probe rows
    @(negedge clk_i); probe_fuses(); mode_i = 2'd2; ded_i = 8'h5A;
    cell_comb_i = 8'h0F; io_pin_i = 8'h33; reg_q_i = 8'hC6;
    step();
    exp_c = cols_of(src_of(2'd2, 8'h5A, 1'b0, 1'b0, 8'h33, 8'hC6, 8'h0F));
    check("R3 column pairs", pt_o, {32'h0, exp_c});

    // R7: shared pins ignored in registered mode
    prev = pt_o;
    @(negedge clk_i); shared_a_i = 1'b1; shared_b_i = 1'b1;
    step();
    check("R7 shared pins ignored", pt_o, prev);
    @(negedge clk_i); mode_i = 2'd3;
    step();
    check("R7 alt encoding", pt_o, prev);

    // R8: complex mode routing, then ignored sources
    @(negedge clk_i); mode_i = 2'd1; shared_a_i = 1'b1; shared_b_i = 1'b0;
    step();
    exp_c = cols_of(src_of(2'd1, 8'h5A, 1'b1, 1'b0, 8'h33, 8'hC6, 8'h0F));
    check("R8 complex routing", pt_o, {32'h0, exp_c});
    prev = pt_o;
    @(negedge clk_i); io_pin_i = io_pin_i ^ 8'h81; reg_q_i = ~reg_q_i; cell_comb_i = ~cell_comb_i;
    step();
    check("R8 outer pins ignored", pt_o, prev);

    // R9: simple mode routing, centre pins ignored
    @(negedge clk_i); mode_i = 2'd0; io_pin_i = 8'b1010_0110;
    step();
    exp_c = cols_of(src_of(2'd0, 8'h5A, 1'b1, 1'b0, 8'b1010_0110, reg_q_i, cell_comb_i));
    check("R9 simple routing", pt_o, {32'h0, exp_c});
    prev = pt_o;
    @(negedge clk_i); io_pin_i = io_pin_i ^ 8'h18; reg_q_i = ~reg_q_i; cell_comb_i = ~cell_comb_i;
    step();
    check("R9 centre pins ignored", pt_o, prev);

    // R4 random, all modes
    for (int m = 0; m < 3; m++) begin
      for (int v = 0; v < 150; v++) begin
        @(negedge clk_i);
        if (v % 10 == 0) begin
          rand_fuses();
          term_en_i = {$urandom, $urandom} | {$urandom, $urandom};
        end
        mode_i = (m == 2) ? 2'(2 + ($urandom & 1)) : 2'(m);
        rand_srcs();
        prev = model();
        step();
        case (m)
          0: check("R4 R9 random simple", pt_o, prev);
          1: check("R4 R8 random complex", pt_o, prev);
          default: check("R4 R7 random registered", pt_o, prev);
        endcase
      end
    end

    // R1 asynchronous reset mid-run
    @(negedge clk_i); fuse_i = '0; term_en_i = '1; rst_ni = 1'b0;
    #1 check("R1 async reset", pt_o, 64'h0);
    finish_run();
  end
endmodule